// File: doc/BRIEF.md
# Priority Interrupt Level Evaluator

This block decides which pending interrupt a processor should take next. It compares every request source against the processor's current priority level and reports the winning level. The sources are a halt input, a memory-error request, a corrected-read-data error request, four hardware levels (0x14 to 0x17) that each hold 32 request slots, and a 16-bit software pending summary. The winner is registered, so the level a consumer sees was computed from the inputs of the previous cycle.

A separate acknowledge port services one level at a time. For a hardware level, it finds the lowest-numbered pending slot, clears that slot and returns the vector programmed for it. For either error level, it returns a fixed vector. Vectors for the 128 hardware slots are written through a configuration port. Hardware slots are raised one per cycle through a raise port.

Top module: `irq_level_arbiter`

## Requirements
- R1: While `halt_req` is high, the next `take_lvl` is 0x1F, whatever the values of `cur_ipl` and every other source.
- R2: Without a halt, a memory-error request yields level 0x1D when `cur_ipl` < 0x1D. It outranks the corrected-error request, the hardware levels and the software levels.
- R3: Without a halt or an eligible memory error, a corrected-error request yields level 0x1A when `cur_ipl` < 0x1A. It outranks the hardware and software levels.
- R4: The hardware levels are scanned from 0x17 down to 0x14. The first level that has any pending slot wins. If the scan reaches a level at or below `cur_ipl`, the result is 0 and software is not considered.
- R5: Software bit b (1 to 15) of `sw_pend` is eligible only when b > `cur_ipl`. The highest eligible bit number wins. Bit 0 never wins. If no source qualifies, the result is 0.
- R6: `take_lvl` is a register. It reflects the inputs present before the latest rising clock edge.
- R7: When `raise_en` is high, the slot `raise_idx` of hardware level 0x14+`raise_lvl` becomes pending.
- R8: An acknowledge at a hardware level (0x14+n) clears the lowest-numbered pending slot of that level. One cycle later, `ack_done` pulses and `ack_vec` holds the vector programmed for that slot. If no slot of that level is pending, `ack_vec` is 0 and nothing changes.
- R9: An acknowledge at level 0x1D returns vector 0x60, and one at level 0x1A returns vector 0x54. Neither raises `ack_err` or changes any pending slot.
- R10: An acknowledge at any level other than 0x14 to 0x17, 0x1A or 0x1D raises `ack_err`, returns vector 0 and changes no pending slot.
- R11: When `cfg_we` is high, `cfg_vec` becomes the vector of slot `cfg_idx` of hardware level 0x14+`cfg_lvl`.
- R12: Reset clears all pending slots and drives `take_lvl`, `ack_vec`, `ack_done` and `ack_err` to 0.
- R13: If a raise and an acknowledge target the same slot in the same cycle, the acknowledge returns that slot's vector and the slot remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_ipl | input | 5 | Current processor priority level |
| halt_req | input | 1 | Non-maskable halt request |
| merr_req | input | 1 | Memory-error request |
| cerr_req | input | 1 | Corrected-read-data error request |
| sw_pend | input | 16 | Software pending summary, bit b requests level b |
| raise_en | input | 1 | Make one hardware slot pending |
| raise_lvl | input | 2 | Hardware level of the raise, offset from 0x14 |
| raise_idx | input | 5 | Slot of the raise |
| cfg_we | input | 1 | Write one vector table entry |
| cfg_lvl | input | 2 | Hardware level of the entry, offset from 0x14 |
| cfg_idx | input | 5 | Slot of the entry |
| cfg_vec | input | 16 | Vector value |
| ack_en | input | 1 | Acknowledge request |
| ack_lvl | input | 5 | Level being acknowledged |
| take_lvl | output | 5 | Registered winning level, 0 for none |
| ack_vec | output | 16 | Vector returned by the last acknowledge |
| ack_done | output | 1 | One-cycle pulse after an acknowledge |
| ack_err | output | 1 | Last acknowledge named an unsupported level |

## Verification
The hardest situation to reach is a hardware level that holds several pending slots while an acknowledge and a raise hit the same slot in one cycle. It is also hard to see that lowest-first ordering and the cleared bits are correct only through `take_lvl`. The stimulus programs a distinct vector into every slot and raises scattered slots on two levels. It then acknowledges repeatedly, checking the returned vectors in order and the drop of `take_lvl` when a level empties. A table of priority-level cases covers each boundary where the current level equals a source's level.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int VEC_W = 16,
  parameter int SLOTS = 32,
  parameter logic [4:0] LVL_HALT = 5'h1F,
  parameter logic [4:0] LVL_MERR = 5'h1D,
  parameter logic [4:0] LVL_CERR = 5'h1A,
  parameter logic [VEC_W-1:0] VEC_MERR = 16'h0060,
  parameter logic [VEC_W-1:0] VEC_CERR = 16'h0054
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               cur_ipl,
  input  logic                     halt_req,
  input  logic                     merr_req,
  input  logic                     cerr_req,
  input  logic [15:0]              sw_pend,
  input  logic                     raise_en,
  input  logic [1:0]               raise_lvl,
  input  logic [$clog2(SLOTS)-1:0] raise_idx,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_lvl,
  input  logic [$clog2(SLOTS)-1:0] cfg_idx,
  input  logic [VEC_W-1:0]         cfg_vec,
  input  logic                     ack_en,
  input  logic [4:0]               ack_lvl,
  output logic [4:0]               take_lvl,
  output logic [VEC_W-1:0]         ack_vec,
  output logic                     ack_done,
  output logic                     ack_err
);
  localparam int IW = $clog2(SLOTS);
  localparam int NHW = 4;
  localparam int HW_BASE = 'h14;
  localparam int HW_TOP = HW_BASE + NHW - 1;

  logic [SLOTS-1:0] pend [NHW];
  logic [VEC_W-1:0] vtab [NHW*SLOTS];

  logic [4:0] lvl_d;
  always_comb begin
    logic done;
    lvl_d = '0;
    done  = 1'b0;
    if (halt_req) begin
      lvl_d = LVL_HALT; done = 1'b1;
    end else if (merr_req && (cur_ipl < LVL_MERR)) begin
      lvl_d = LVL_MERR; done = 1'b1;
    end else if (cerr_req && (cur_ipl < LVL_CERR)) begin
      lvl_d = LVL_CERR; done = 1'b1;
    end
    for (int i = NHW - 1; i >= 0; i--) begin
      if (!done) begin
        if (HW_BASE + i <= int'(cur_ipl)) done = 1'b1;
        else if (|pend[i]) begin
          lvl_d = 5'(HW_BASE + i); done = 1'b1;
        end
      end
    end
    for (int b = 15; b >= 1; b--) begin
      if (!done && sw_pend[b] && (b > int'(cur_ipl))) begin
        lvl_d = 5'(b); done = 1'b1;
      end
    end
  end

  wire       ack_hw  = (int'(ack_lvl) >= HW_BASE) && (int'(ack_lvl) <= HW_TOP);
  wire [1:0] ack_sel = 2'(ack_lvl - 5'(HW_BASE));

  logic          hit;
  logic [IW-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int b = SLOTS - 1; b >= 0; b--) begin
      if (pend[ack_sel][b]) begin
        hit = 1'b1; hit_idx = IW'(b);
      end
    end
  end

  logic [VEC_W-1:0] vec_d;
  logic             err_d;
  logic             clr_go;
  always_comb begin
    vec_d  = '0;
    err_d  = 1'b0;
    clr_go = 1'b0;
    if (ack_lvl == LVL_MERR)      vec_d = VEC_MERR;
    else if (ack_lvl == LVL_CERR) vec_d = VEC_CERR;
    else if (ack_hw) begin
      if (hit) begin
        vec_d  = vtab[{ack_sel, hit_idx}];
        clr_go = ack_en;
      end
    end else err_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) vtab[{cfg_lvl, cfg_idx}] <= cfg_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NHW; i++) pend[i] <= '0;
      take_lvl <= '0;
      ack_vec  <= '0;
      ack_done <= 1'b0;
      ack_err  <= 1'b0;
    end else begin
      for (int i = 0; i < NHW; i++) begin
        logic [SLOTS-1:0] clr, set;
        clr = (clr_go && (ack_sel == 2'(i))) ? (SLOTS'(1) << hit_idx) : '0;
        set = (raise_en && (raise_lvl == 2'(i))) ? (SLOTS'(1) << raise_idx) : '0;
        pend[i] <= (pend[i] & ~clr) | set;
      end
      take_lvl <= lvl_d;
      ack_done <= ack_en;
      ack_err  <= ack_en && err_d;
      ack_vec  <= ack_en ? vec_d : '0;
    end
  end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       cur_ipl,
  input logic             halt_req,
  input logic             ack_en,
  input logic [4:0]       ack_lvl,
  input logic [4:0]       take_lvl,
  input logic [VEC_W-1:0] ack_vec,
  input logic             ack_done,
  input logic             ack_err
);
  a_r1_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> take_lvl == 5'h1F);

  a_r5_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_req |=> (take_lvl == 5'h00) || (take_lvl > $past(cur_ipl)));

  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> ack_done);

  a_r8_no_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_en |=> !ack_done && !ack_err && ack_vec == '0);

  a_r9_merr_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && ack_lvl == 5'h1D) |=> (ack_vec == VEC_W'(16'h0060)) && !ack_err);

  a_r9_cerr_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && ack_lvl == 5'h1A) |=> (ack_vec == VEC_W'(16'h0054)) && !ack_err);

  a_r10_bad_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && (ack_lvl < 5'h14 || ack_lvl == 5'h18)) |=> ack_err && ack_vec == '0);
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_ipl(cur_ipl), .halt_req(halt_req),
  .ack_en(ack_en), .ack_lvl(ack_lvl), .take_lvl(take_lvl),
  .ack_vec(ack_vec), .ack_done(ack_done), .ack_err(ack_err)
);

// File: tb/test_irq_level_arbiter.sv
`timescale 1ns/1ps
module test_irq_level_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cur_ipl = '0;
  logic        halt_req = 1'b0, merr_req = 1'b0, cerr_req = 1'b0;
  logic [15:0] sw_pend = '0;
  logic        raise_en = 1'b0;
  logic [1:0]  raise_lvl = '0;
  logic [4:0]  raise_idx = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_lvl = '0;
  logic [4:0]  cfg_idx = '0;
  logic [15:0] cfg_vec = '0;
  logic        ack_en = 1'b0;
  logic [4:0]  ack_lvl = '0;
  logic [4:0]  take_lvl;
  logic [15:0] ack_vec;
  logic        ack_done, ack_err;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_level_arbiter i_irq_level_arbiter (.*);

  // {halt, merr, cerr, ipl[4:0], sw[15:0], expected[4:0]}
  localparam int NV = 17;
  localparam logic [28:0] TAB [NV] = '{
    {3'b000, 5'h00, 16'h0000, 5'h00},
    {3'b100, 5'h1F, 16'h0000, 5'h1F},
    {3'b111, 5'h00, 16'hFFFF, 5'h1F},
    {3'b011, 5'h00, 16'hFFFF, 5'h1D},
    {3'b010, 5'h1D, 16'h0000, 5'h00},
    {3'b011, 5'h1C, 16'h0000, 5'h1D},
    {3'b001, 5'h1A, 16'h0000, 5'h00},
    {3'b001, 5'h19, 16'h0000, 5'h1A},
    {3'b000, 5'h00, 16'h0001, 5'h00},
    {3'b000, 5'h00, 16'h0006, 5'h02},
    {3'b000, 5'h03, 16'h000F, 5'h00},
    {3'b000, 5'h03, 16'h0018, 5'h04},
    {3'b000, 5'h0D, 16'h6000, 5'h0E},
    {3'b000, 5'h0E, 16'h8000, 5'h0F},
    {3'b000, 5'h0D, 16'h8000, 5'h0F},
    {3'b000, 5'h0F, 16'hFFFF, 5'h00},
    {3'b010, 5'h1E, 16'h0000, 5'h00}
  };

  function automatic logic [15:0] vexp(int lvl, int idx);
    return 16'(16'h0100 + lvl * 16'h0080 + idx * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic raise(int lvl, int idx);
    raise_en = 1'b1; raise_lvl = 2'(lvl); raise_idx = 5'(idx);
    cyc();
    raise_en = 1'b0;
  endtask

  task automatic ack(logic [4:0] lvl);
    ack_en = 1'b1; ack_lvl = lvl;
    cyc();
    ack_en = 1'b0;
  endtask

  task automatic eval(logic [4:0] ipl, logic [15:0] sw);
    cur_ipl = ipl; sw_pend = sw;
    cyc();
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R6: watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R12 reset take_lvl", 32'(take_lvl), 0);
    chk("R12 reset ack_vec", 32'(ack_vec), 0);
    chk("R12 reset ack_done/err", {ack_done, ack_err}, 0);
    rst_n = 1'b1;
    cyc();

    for (int k = 0; k < NV; k++) begin
      {halt_req, merr_req, cerr_req} = TAB[k][28:26];
      cur_ipl = TAB[k][25:21];
      sw_pend = TAB[k][20:5];
      cyc();
      chk($sformatf("R1-5 table row %0d", k), 32'(take_lvl), 32'(TAB[k][4:0]));
    end
    {halt_req, merr_req, cerr_req} = 3'b000;

    // R6: result appears only after the clock edge
    eval(5'h00, 16'h0000);
    halt_req = 1'b1;
    #1 chk("R6 not yet registered", 32'(take_lvl), 0);
    cyc();
    chk("R6 registered halt", 32'(take_lvl), 32'h1F);
    halt_req = 1'b0;

    // R11: program every slot
    cfg_we = 1'b1;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 32; s++) begin
        cfg_lvl = 2'(l); cfg_idx = 5'(s); cfg_vec = vexp(l, s);
        cyc();
      end
    cfg_we = 1'b0;

    // R7, R4
    raise(0, 9); raise(0, 5); raise(2, 31);
    eval(5'h00, 16'hFFFF);
    chk("R4 hardware over software", 32'(take_lvl), 32'h16);
    eval(5'h16, 16'h0000);
    chk("R4 scan stops at current level", 32'(take_lvl), 0);
    eval(5'h15, 16'h0000);
    chk("R4 level above current", 32'(take_lvl), 32'h16);
    merr_req = 1'b1;
    eval(5'h00, 16'h0000);
    chk("R2 memory error over hardware", 32'(take_lvl), 32'h1D);
    merr_req = 1'b0;

    // R8, R11
    ack(5'h16);
    chk("R8 R11 vector of slot 31 level 0x16", 32'(ack_vec), 32'(vexp(2, 31)));
    chk("R8 ack_done", 32'(ack_done), 1);
    cyc();
    chk("R8 level 0x16 emptied", 32'(take_lvl), 32'h14);
    ack(5'h14);
    chk("R8 lowest slot first", 32'(ack_vec), 32'(vexp(0, 5)));
    ack(5'h14);
    chk("R8 next slot", 32'(ack_vec), 32'(vexp(0, 9)));
    ack(5'h14);
    chk("R8 empty level vector 0", 32'(ack_vec), 0);
    chk("R8 empty level no error", {ack_done, ack_err}, 32'b10);
    eval(5'h00, 16'h0004);
    chk("R8 all slots cleared", 32'(take_lvl), 32'h02);

    // R9, R10
    raise(3, 3);
    ack(5'h1D);
    chk("R9 memory-error vector", 32'(ack_vec), 32'h60);
    ack(5'h1A);
    chk("R9 corrected-error vector", {ack_err, ack_vec}, 32'h54);
    cyc();
    chk("R9 pending slot kept", 32'(take_lvl), 32'h17);
    ack(5'h18);
    chk("R10 level 0x18 error", {ack_err, ack_vec}, 32'h10000);
    ack(5'h10);
    chk("R10 level 0x10 error", {ack_err, ack_vec}, 32'h10000);
    cyc();
    chk("R10 pending slot kept", 32'(take_lvl), 32'h17);

    // R13
    raise_en = 1'b1; raise_lvl = 2'd3; raise_idx = 5'd3;
    ack(5'h17);
    raise_en = 1'b0;
    chk("R13 vector returned", 32'(ack_vec), 32'(vexp(3, 3)));
    cyc();
    chk("R13 slot still pending", 32'(take_lvl), 32'h17);
    ack(5'h17);
    eval(5'h00, 16'h0000);
    chk("R13 slot cleared by second ack", 32'(take_lvl), 0);

    // R3 with hardware pending
    raise(1, 0);
    cerr_req = 1'b1;
    eval(5'h00, 16'h0000);
    chk("R3 corrected error over hardware", 32'(take_lvl), 32'h1A);
    cerr_req = 1'b0;

    // R12: reset mid-run clears pending
    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    eval(5'h00, 16'h0000);
    chk("R12 pending cleared by reset", 32'(take_lvl), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule